// File: doc/BRIEF.md
# Triggered Pattern Sequencer

This block walks through a programmed list of display patterns and produces the two timing strobes a camera or sensor needs to stay aligned with what is being shown. One output is high while a pattern is being exposed, and the other marks the moment a new pattern sequence begins. The current position in the list is presented as a pattern index, plus a sub-pattern index when full-colour patterns are enabled. A full-colour pattern is shown as three consecutive exposures.

Four trigger disciplines are chosen by `mode_sel`:
- **Vertical-sync start (0):** a vertical sync edge plays one whole sequence without further input.
- **External advance (1):** each trigger pulse exposes one pattern and moves to the next. A run/stop level gates this mode. If the run level drops mid-pattern, the exposure is cut short, and the same pattern is shown again from its first sub-exposure when the level returns.
- **Pair toggle (2):** one trigger alternates between the two members of a pattern pair, and the second trigger steps to the next pair.
- **Parked (3):** no exposures are started.

The exposure length comes from a programmable tick count. The asynchronous trigger inputs are resynchronised to the block clock before use.

Top module: `pat_sequencer`

## Requirements
- R1: While reset is asserted, `trig_out_1`, `trig_out_2`, `pat_idx` and `sub_idx` are all 0.
- R2: `vsync`, `trig_in_1` and `trig_in_2` pass through a two-flop synchronizer before use, and only a low-to-high transition counts as a trigger. A level held high for many cycles produces exactly one trigger.
- R3: Every exposure holds `trig_out_1` high for exactly `exp_ticks` cycles, with a value of 0 treated as 1. At least one low cycle separates two exposures.
- R4: With `mode_sel` = 0, a rising `vsync` exposes `seq_len` patterns back to back and then waits for the next `vsync`. In this mode `trig_in_1` has no effect.
- R5: `trig_out_2` is a one-cycle pulse that coincides with the first `trig_out_1` cycle of the first sub-exposure of a pattern at sequence position 0. In mode 2 it marks instead the even member of a pair.
- R6: The pattern after index `pat_count`-1 is index 0, and that pattern opens a new sequence (`trig_out_2` pulses). Reaching the end of the list also ends the current sequence in mode 0.
- R7: With `mode_sel` = 1, a rising `trig_in_1` while `trig_in_2` is high exposes the current pattern, and the index then advances by one. A `trig_in_1` edge while `trig_in_2` is low, and any `vsync` edge, leave `pat_idx` unchanged and start no exposure.
- R8: In mode 1, a low `trig_in_2` during a pattern ends `trig_out_1` early and keeps `pat_idx` unchanged. When `trig_in_2` rises again, the same pattern is exposed in full from sub-exposure 0.
- R9: With `color_en` = 1, each pattern is shown as three exposures with `sub_idx` = 0, 1 and 2 in that order. With `color_en` = 0, `sub_idx` stays 0.
- R10: With `mode_sel` = 2, a rising `trig_in_1` exposes `pat_idx` and then flips its least significant bit. A rising `trig_in_2` while idle moves to the next even index, wrapping to 0 when that index reaches `pat_count`.
- R11: With `mode_sel` = 3, no edge on any trigger input starts an exposure.
- R12: `pat_idx` and `sub_idx` do not change while `trig_out_1` is high, and `pat_idx` stays below a non-zero `pat_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_sel | input | 2 | Trigger discipline: 0 vsync, 1 external advance, 2 pair toggle, 3 parked |
| pat_count | input | IDX_W+1 | Number of patterns in the list |
| seq_len | input | IDX_W+1 | Patterns per sequence |
| exp_ticks | input | EXP_W | Exposure length in clock cycles (0 acts as 1) |
| color_en | input | 1 | Show each pattern as three sub-exposures |
| vsync | input | 1 | Asynchronous vertical sync |
| trig_in_1 | input | 1 | Asynchronous advance / toggle trigger |
| trig_in_2 | input | 1 | Asynchronous run level (mode 1) or pair step (mode 2) |
| pat_idx | output | IDX_W | Current pattern index |
| sub_idx | output | 2 | Current colour sub-exposure |
| trig_out_1 | output | 1 | High while a pattern is exposed |
| trig_out_2 | output | 1 | One-cycle pulse at the start of a sequence |

## Verification
The bench builds the block with IDX_W = 4 and EXP_W = 8.

With these widths, list lengths of four to six patterns are practical. That makes it possible to end the list both exactly on a sequence boundary and part way through a sequence, and to wrap a pair step back to index 0.

An 8-bit tick count allows a 20-cycle exposure. That is long enough to drop the run level well inside an exposure and see a shortened strobe. The same width also covers the zero-tick case, which produces one-cycle strobes that sit against the one-cycle gap between exposures.

// File: rtl/patseq_pkg.sv
package patseq_pkg;

  typedef enum logic [1:0] {
    MODE_VSYNC = 2'd0,
    MODE_EXT   = 2'd1,
    MODE_PAIR  = 2'd2,
    MODE_OFF   = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

  localparam int unsigned SUB_W    = 2;
  localparam logic [1:0]  SUB_LAST = 2'd2;

endpackage

// File: rtl/patseq_rst_sync.sv
module patseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/patseq_sync.sv
module patseq_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level
);

  localparam int unsigned TOP = STAGES - 1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
      end
    end

    assign level[b] = chain_q[TOP];
  end

endmodule

// File: rtl/patseq_expo_timer.sv
module patseq_expo_timer #(
  parameter int unsigned EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [EXP_W-1:0] ticks,
  output logic             active,
  output logic             done
);

  logic [EXP_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             cnt_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    done   = act_q && (cnt_q == '0);
    cnt_en = load || act_q;
    if (load) begin
      act_d = 1'b1;
      cnt_d = (ticks == '0) ? '0 : ticks - EXP_W'(1);
    end else if (abort) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - EXP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign active = act_q;

endmodule

// File: rtl/patseq_ctrl.sv
module patseq_ctrl
  import patseq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [IDX_W:0]   pat_count,
  input  logic [IDX_W:0]   seq_len,
  input  logic             color_en,
  input  logic [2:0]       trig_lvl,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic             tmr_abort,
  output logic [IDX_W-1:0] pat_idx,
  output logic [SUB_W-1:0] sub_idx,
  output logic             seq_mark
);

  localparam int unsigned CNT_W = IDX_W + 1;

  trig_mode_e       mode;
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] seq_q, seq_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             mark_q, mark_d;
  logic [2:0]       prev_q;
  logic [2:0]       rise;
  logic             vs_rise, t1_rise, t2_rise, run_lvl;
  logic [CNT_W-1:0] next_lin, pair_next, seq_next;
  logic             wrap_lin, wrap_pair, seq_end, last_pat, first_d;

  assign mode    = trig_mode_e'(mode_sel);
  assign rise    = trig_lvl & ~prev_q;
  assign vs_rise = rise[0];
  assign t1_rise = rise[1];
  assign t2_rise = rise[2];
  assign run_lvl = trig_lvl[2];

  always_comb begin
    next_lin  = {1'b0, idx_q} + CNT_W'(1);
    pair_next = {1'b0, idx_q | IDX_W'(1)} + CNT_W'(1);
    seq_next  = {1'b0, seq_q} + CNT_W'(1);
    wrap_lin  = next_lin >= pat_count;
    wrap_pair = pair_next >= pat_count;
    seq_end   = seq_next >= seq_len;
  end

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    seq_d     = seq_q;
    sub_d     = sub_q;
    tmr_load  = 1'b0;
    tmr_abort = 1'b0;
    last_pat  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        unique case (mode)
          MODE_VSYNC: if (vs_rise) begin
            tmr_load = 1'b1;
            state_d  = ST_RUN;
          end
          MODE_EXT: if (t1_rise && run_lvl) begin
            tmr_load = 1'b1;
            state_d  = ST_RUN;
          end
          MODE_PAIR: begin
            if (t1_rise) begin
              tmr_load = 1'b1;
              state_d  = ST_RUN;
            end else if (t2_rise) begin
              idx_d = wrap_pair ? '0 : pair_next[IDX_W-1:0];
              sub_d = '0;
            end
          end
          default: ;
        endcase
      end
      ST_RUN: begin
        if (mode == MODE_EXT && !run_lvl) begin
          tmr_abort = 1'b1;
          sub_d     = '0;
          state_d   = ST_HOLD;
        end else if (tmr_done) begin
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (mode == MODE_EXT && !run_lvl) begin
          sub_d   = '0;
          state_d = ST_HOLD;
        end else if (color_en && sub_q != SUB_LAST) begin
          sub_d    = sub_q + 2'd1;
          tmr_load = 1'b1;
          state_d  = ST_RUN;
        end else begin
          sub_d = '0;
          if (mode == MODE_PAIR) begin
            if (idx_q[0] || !wrap_lin) begin
              idx_d = idx_q ^ IDX_W'(1);
            end
            state_d = ST_IDLE;
          end else begin
            if (wrap_lin) begin
              idx_d    = '0;
              seq_d    = '0;
              last_pat = 1'b1;
            end else if (seq_end) begin
              idx_d    = next_lin[IDX_W-1:0];
              seq_d    = '0;
              last_pat = 1'b1;
            end else begin
              idx_d = next_lin[IDX_W-1:0];
              seq_d = seq_next[IDX_W-1:0];
            end
            if (mode == MODE_VSYNC && !last_pat) begin
              tmr_load = 1'b1;
              state_d  = ST_RUN;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      end
      ST_HOLD: begin
        if (mode != MODE_EXT) begin
          state_d = ST_IDLE;
        end else if (run_lvl) begin
          tmr_load = 1'b1;
          state_d  = ST_RUN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (mode == MODE_PAIR) begin
      first_d = (sub_d == '0) && !idx_d[0];
    end else begin
      first_d = (sub_d == '0) && (seq_d == '0);
    end
    mark_d = tmr_load && first_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      seq_q   <= '0;
      sub_q   <= '0;
      mark_q  <= 1'b0;
      prev_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      seq_q   <= seq_d;
      sub_q   <= sub_d;
      mark_q  <= mark_d;
      prev_q  <= trig_lvl;
    end
  end

  assign pat_idx  = idx_q;
  assign sub_idx  = sub_q;
  assign seq_mark = mark_q;

endmodule

// File: rtl/pat_sequencer.sv
module pat_sequencer #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [IDX_W:0]   pat_count,
  input  logic [IDX_W:0]   seq_len,
  input  logic [EXP_W-1:0] exp_ticks,
  input  logic             color_en,
  input  logic             vsync,
  input  logic             trig_in_1,
  input  logic             trig_in_2,
  output logic [IDX_W-1:0] pat_idx,
  output logic [1:0]       sub_idx,
  output logic             trig_out_1,
  output logic             trig_out_2
);

  localparam int unsigned N_TRIG = 3;

  logic              rst_n_int;
  logic [N_TRIG-1:0] trig_lvl;
  logic              tmr_load, tmr_abort, tmr_done;

  patseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  patseq_sync #(.N(N_TRIG), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({trig_in_2, trig_in_1, vsync}),
    .level    (trig_lvl)
  );

  patseq_expo_timer #(.EXP_W(EXP_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (tmr_load),
    .abort  (tmr_abort),
    .ticks  (exp_ticks),
    .active (trig_out_1),
    .done   (tmr_done)
  );

  patseq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mode_sel  (mode_sel),
    .pat_count (pat_count),
    .seq_len   (seq_len),
    .color_en  (color_en),
    .trig_lvl  (trig_lvl),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_abort (tmr_abort),
    .pat_idx   (pat_idx),
    .sub_idx   (sub_idx),
    .seq_mark  (trig_out_2)
  );

endmodule

// File: rtl/pat_sequencer_chk.sv
module pat_sequencer_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic [IDX_W:0]   pat_count,
  input logic             color_en,
  input logic [IDX_W-1:0] pat_idx,
  input logic [1:0]       sub_idx,
  input logic             trig_out_1,
  input logic             trig_out_2
);

  // R5
  mark_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_2 |-> trig_out_1);

  // R5
  mark_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_2 |=> !trig_out_2);

  // R12
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out_1 && $past(trig_out_1)) |-> ($stable(pat_idx) && $stable(sub_idx)));

  // R12
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_count != '0) |-> ({1'b0, pat_idx} < pat_count));

  // R9
  sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_idx != 2'd0) |-> (color_en && sub_idx <= 2'd2));

  // R11
  parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd3 && $past(mode_sel) == 2'd3) |-> !$rose(trig_out_1));

endmodule

bind pat_sequencer pat_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .pat_count  (pat_count),
  .color_en   (color_en),
  .pat_idx    (pat_idx),
  .sub_idx    (sub_idx),
  .trig_out_1 (trig_out_1),
  .trig_out_2 (trig_out_2)
);

// File: tb/tb_pat_sequencer.sv
module tb_pat_sequencer;

  localparam int unsigned IDX_W = 4;
  localparam int unsigned EXP_W = 8;

  logic             clk;
  logic             rst_n;
  logic [1:0]       mode_sel;
  logic [IDX_W:0]   pat_count;
  logic [IDX_W:0]   seq_len;
  logic [EXP_W-1:0] exp_ticks;
  logic             color_en;
  logic             vsync, trig_in_1, trig_in_2;
  logic [IDX_W-1:0] pat_idx;
  logic [1:0]       sub_idx;
  logic             trig_out_1, trig_out_2;

  pat_sequencer #(.IDX_W(IDX_W), .EXP_W(EXP_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pat_count(pat_count),
    .seq_len(seq_len), .exp_ticks(exp_ticks), .color_en(color_en),
    .vsync(vsync), .trig_in_1(trig_in_1), .trig_in_2(trig_in_2),
    .pat_idx(pat_idx), .sub_idx(sub_idx),
    .trig_out_1(trig_out_1), .trig_out_2(trig_out_2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int    idx;
    int    sub;
    int    mark;
    int    width;
    bit    cut;
    string req;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_exp(input int idx, input int sub, input int mark,
                            input int width, input bit cut, input string req);
    item_t it;
    it.idx = idx; it.sub = sub; it.mark = mark;
    it.width = width; it.cut = cut; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: measures each trig_out_1 window and compares with the queue
  bit mon_prev;
  int cur_w, cur_idx, cur_sub, cur_mark;
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_prev = 1'b0;
    end else begin
      if (trig_out_1 && !mon_prev) begin
        cur_idx = int'(pat_idx); cur_sub = int'(sub_idx);
        cur_mark = int'(trig_out_2); cur_w = 1;
      end else if (trig_out_1) begin
        cur_w++;
      end else if (mon_prev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R11", "unexpected exposure of pattern", cur_idx, -1);
        end else begin
          item_t e;
          e = sb_q.pop_front();
          check(cur_idx == e.idx, e.req, "pattern index", cur_idx, e.idx);
          check(cur_sub == e.sub, e.req, "sub index", cur_sub, e.sub);
          check(cur_mark == e.mark, e.req, "sequence mark", cur_mark, e.mark);
          if (e.cut) check(cur_w < e.width, e.req, "cut exposure width", cur_w, e.width);
          else       check(cur_w == e.width, e.req, "exposure width", cur_w, e.width);
        end
      end
      mon_prev = trig_out_1;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which, input int len);
    if (which == 0) vsync = 1'b1;
    else if (which == 1) trig_in_1 = 1'b1;
    else trig_in_2 = 1'b1;
    wait_cyc(len);
    if (which == 0) vsync = 1'b0;
    else if (which == 1) trig_in_1 = 1'b0;
    else trig_in_2 = 1'b0;
  endtask

  task automatic do_reset(input int m, input int pc, input int sl,
                          input int ex, input bit col);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = 2'(m); pat_count = (IDX_W+1)'(pc); seq_len = (IDX_W+1)'(sl);
    exp_ticks = EXP_W'(ex); color_en = col;
    vsync = 1'b0; trig_in_1 = 1'b0; trig_in_2 = 1'b0;
    wait_cyc(3);
    // R1 reset values
    check(trig_out_1 == 1'b0, "R1", "trig_out_1 in reset", int'(trig_out_1), 0);
    check(trig_out_2 == 1'b0, "R1", "trig_out_2 in reset", int'(trig_out_2), 0);
    check(pat_idx == '0, "R1", "pat_idx in reset", int'(pat_idx), 0);
    check(sub_idx == '0, "R1", "sub_idx in reset", int'(sub_idx), 0);
    rst_n = 1'b1;
    wait_cyc(5);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_sel = '0; pat_count = '0; seq_len = '0; exp_ticks = '0; color_en = 1'b0;
    vsync = 1'b0; trig_in_1 = 1'b0; trig_in_2 = 1'b0;

    // mode 0: list of 6, sequences of 3, 4-tick exposures
    do_reset(0, 6, 3, 4, 1'b0);
    pulse(1, 3); wait_cyc(30);
    check(pat_idx == 4'd0, "R4", "index after trig_in_1 in vsync mode", int'(pat_idx), 0);
    expect_exp(0, 0, 1, 4, 0, "R4"); expect_exp(1, 0, 0, 4, 0, "R4");
    expect_exp(2, 0, 0, 4, 0, "R4");
    pulse(0, 3); wait_cyc(60);
    expect_exp(3, 0, 1, 4, 0, "R5"); expect_exp(4, 0, 0, 4, 0, "R5");
    expect_exp(5, 0, 0, 4, 0, "R5");
    pulse(0, 3); wait_cyc(60);
    expect_exp(0, 0, 1, 4, 0, "R6"); expect_exp(1, 0, 0, 4, 0, "R6");
    expect_exp(2, 0, 0, 4, 0, "R6");
    pulse(0, 3); wait_cyc(60);

    // mode 0: list of 5 ends mid-sequence, zero ticks act as one
    do_reset(0, 5, 3, 0, 1'b0);
    expect_exp(0, 0, 1, 1, 0, "R3"); expect_exp(1, 0, 0, 1, 0, "R3");
    expect_exp(2, 0, 0, 1, 0, "R3");
    pulse(0, 3); wait_cyc(40);
    expect_exp(3, 0, 1, 1, 0, "R6"); expect_exp(4, 0, 0, 1, 0, "R6");
    pulse(0, 3); wait_cyc(40);
    check(pat_idx == 4'd0, "R6", "index after end of list", int'(pat_idx), 0);
    expect_exp(0, 0, 1, 1, 0, "R6"); expect_exp(1, 0, 0, 1, 0, "R6");
    expect_exp(2, 0, 0, 1, 0, "R6");
    pulse(0, 3); wait_cyc(40);

    // colour: three sub-exposures per pattern
    do_reset(0, 4, 2, 3, 1'b1);
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 3; s++) begin
        expect_exp(p, s, (p == 0 && s == 0) ? 1 : 0, 3, 0, "R9");
      end
    end
    pulse(0, 3); wait_cyc(80);

    // mode 1: external advance
    do_reset(1, 4, 3, 4, 1'b0);
    trig_in_2 = 1'b1; wait_cyc(5);
    pulse(0, 3); wait_cyc(30);
    check(pat_idx == 4'd0, "R7", "index after vsync in advance mode", int'(pat_idx), 0);
    expect_exp(0, 0, 1, 4, 0, "R2");
    pulse(1, 40); wait_cyc(30);
    expect_exp(1, 0, 0, 4, 0, "R7"); pulse(1, 3); wait_cyc(30);
    expect_exp(2, 0, 0, 4, 0, "R7"); pulse(1, 3); wait_cyc(30);
    expect_exp(3, 0, 1, 4, 0, "R5"); pulse(1, 3); wait_cyc(30);
    expect_exp(0, 0, 1, 4, 0, "R6"); pulse(1, 3); wait_cyc(30);
    trig_in_2 = 1'b0; wait_cyc(5);
    pulse(1, 3); wait_cyc(30);
    check(pat_idx == 4'd1, "R7", "index after trigger while stopped", int'(pat_idx), 1);

    // mode 1: stop mid-pattern and resume
    do_reset(1, 4, 2, 20, 1'b0);
    trig_in_2 = 1'b1; wait_cyc(5);
    expect_exp(0, 0, 1, 20, 0, "R7"); pulse(1, 3); wait_cyc(40);
    expect_exp(1, 0, 0, 20, 1, "R8"); pulse(1, 3); wait_cyc(10);
    trig_in_2 = 1'b0; wait_cyc(15);
    check(trig_out_1 == 1'b0, "R8", "strobe while stopped", int'(trig_out_1), 0);
    check(pat_idx == 4'd1, "R8", "index while stopped", int'(pat_idx), 1);
    expect_exp(1, 0, 0, 20, 0, "R8");
    trig_in_2 = 1'b1; wait_cyc(40);
    expect_exp(2, 0, 1, 20, 0, "R8"); pulse(1, 3); wait_cyc(40);

    // mode 2: pairs
    do_reset(2, 4, 2, 4, 1'b0);
    expect_exp(0, 0, 1, 4, 0, "R10"); pulse(1, 3); wait_cyc(30);
    expect_exp(1, 0, 0, 4, 0, "R10"); pulse(1, 3); wait_cyc(30);
    expect_exp(0, 0, 1, 4, 0, "R10"); pulse(1, 3); wait_cyc(30);
    pulse(2, 3); wait_cyc(20);
    check(pat_idx == 4'd2, "R10", "index after pair step", int'(pat_idx), 2);
    expect_exp(2, 0, 1, 4, 0, "R10"); pulse(1, 3); wait_cyc(30);
    expect_exp(3, 0, 0, 4, 0, "R10"); pulse(1, 3); wait_cyc(30);
    pulse(2, 3); wait_cyc(20);
    check(pat_idx == 4'd0, "R10", "index after pair wrap", int'(pat_idx), 0);
    expect_exp(0, 0, 1, 4, 0, "R10"); pulse(1, 3); wait_cyc(30);

    // mode 3: parked
    do_reset(3, 4, 2, 4, 1'b0);
    pulse(0, 3); wait_cyc(10); pulse(1, 3); wait_cyc(10); pulse(2, 3); wait_cyc(30);
    check(pat_idx == 4'd0, "R11", "index while parked", int'(pat_idx), 0);

    check(sb_q.size() == 0, "R3", "exposures still expected", sb_q.size(), 0);
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end

endmodule